// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Arbiter

This block sits beside the status logic of a 16550-style UART. It collects the raw condition signals from the line status, receiver, transmitter and modem status logic and keeps each one pending until that source's own clearing event occurs. It then raises a single interrupt line and presents an 8-bit identification value whose low nibble names the highest-priority source that is both pending and enabled.

The register read and write strobes come from the host bus decoder. Each strobe is one clock wide, in the cycle in which the access takes place. The enable bits come from the interrupt-enable register and `fifo_mode_i` comes from the FIFO control logic. The baud generator, FIFOs, shifters and bus decoding are outside this block. All pending flags are registered. The interrupt output and the identification value are combinational from those flags, the enables and the FIFO mode, so a condition presented before a clock edge is visible just after that edge.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0 and `iir_o` is 8'h01. Whenever no enabled source is pending, `iir_o[3:0]` is 4'b0001, where bit 0 = 1 means nothing is pending.
- R2: A `lsr_evt_i` pulse makes the line-status source pending. Its code is 4'b0110. An `lsr_rd_i` strobe clears it. If an event and a read fall in the same cycle, the source stays pending.
- R3: Received-data-available is pending in the cycle after a cycle with `rx_avail_i`=1 and no `rbr_rd_i`. It reports code 4'b0100. It clears after a cycle with `rx_avail_i`=0 or with an `rbr_rd_i` strobe.
- R4: A `tmo_evt_i` pulse sets the character-timeout source, but only while `fifo_mode_i`=1. It reports code 4'b1100 and is only reported while `fifo_mode_i`=1. It is cleared by `rbr_rd_i` or by `fifo_mode_i`=0. When both second-level sources are pending, the timeout code is reported.
- R5: The transmit-empty source becomes pending on a rising edge of `thr_empty_i`. It also becomes pending in a cycle where `ien_i[1]` rises while `thr_empty_i`=1. It reports code 4'b0010. A new set wins over a clear in the same cycle.
- R6: A `thr_wr_i` strobe clears the transmit-empty source. An `iir_rd_i` strobe clears it only when `iir_o[3:0]` equals 4'b0010 in the cycle of the strobe. Any other IIR read leaves it pending.
- R7: A `msr_evt_i` pulse makes the modem-status source pending. It reports code 4'b0000 and is cleared by `msr_rd_i`. If an event and a read fall in the same cycle, the source stays pending.
- R8: Each source is gated by its enable before arbitration: `ien_i[0]` gates received data and timeout, `ien_i[1]` transmit empty, `ien_i[2]` line status and `ien_i[3]` modem status. A disabled source is neither reported nor signalled, but it stays held and appears once it is enabled.
- R9: `irq_o` is 1 exactly when at least one enabled source is pending, which is exactly when `iir_o[0]` is 0.
- R10: `iir_o[7:6]` reads 2'b11 when `fifo_mode_i`=1 and 2'b00 otherwise. `iir_o[5:4]` is always 0. `iir_o[3]` can be 1 only when `fifo_mode_i`=1.
- R11: Priority from highest to lowest is line status, then character timeout, then received data, then transmit empty, then modem status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_mode_i | input | 1 | FIFO mode active |
| ien_i | input | 4 | Source enables (see R8) |
| lsr_evt_i | input | 1 | Line error or break detected (pulse) |
| rx_avail_i | input | 1 | Receive data available or FIFO at trigger (level) |
| tmo_evt_i | input | 1 | Character timeout detected (pulse) |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| msr_evt_i | input | 1 | Modem line change detected (pulse) |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification value |

## Verification
The assertions check the following on every cycle: the fixed upper bits, bit 3 only in FIFO mode, the agreement between `irq_o` and the "none pending" bit, the code reported for the top source, and the clearing effect of each read strobe when no new event arrives with it. The bench scenarios are needed for the ordering effects. These are a transmit-empty flag that survives an IIR read made while a higher source was showing, a flag that appears after a late enable, the enable-rise setting of transmit-empty, and the interplay of clears and sets over long random sequences.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IEN_W = 4;
    localparam int ID_W  = 4;
    localparam int IIR_W = 8;

    // enable bit positions
    localparam int EN_RX  = 0;
    localparam int EN_TX  = 1;
    localparam int EN_LS  = 2;
    localparam int EN_MS  = 3;

    // identification codes
    localparam logic [ID_W-1:0] ID_NONE = 4'b0001;
    localparam logic [ID_W-1:0] ID_LS   = 4'b0110;
    localparam logic [ID_W-1:0] ID_RDA  = 4'b0100;
    localparam logic [ID_W-1:0] ID_TMO  = 4'b1100;
    localparam logic [ID_W-1:0] ID_THRE = 4'b0010;
    localparam logic [ID_W-1:0] ID_MS   = 4'b0000;

    typedef struct packed {
        logic ls;
        logic tmo;
        logic rda;
        logic thre;
        logic ms;
    } irq_pend_t;

endpackage

// File: rtl/uart_irq_src_track.sv
module uart_irq_src_track
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_mode_i,
    input  logic            tx_en_i,
    input  logic            lsr_evt_i,
    input  logic            rx_avail_i,
    input  logic            tmo_evt_i,
    input  logic            thr_empty_i,
    input  logic            msr_evt_i,
    input  logic            lsr_rd_i,
    input  logic            rbr_rd_i,
    input  logic            thr_wr_i,
    input  logic            iir_rd_i,
    input  logic            msr_rd_i,
    input  logic [ID_W-1:0] shown_id_i,
    output irq_pend_t       pend_o
);

    typedef struct packed {
        irq_pend_t pend;
        logic      empty_prev;
        logic      tx_en_prev;
    } track_state_t;

    track_state_t st_q, st_d;
    logic thre_set, thre_clr;

    always_comb begin
        st_d = st_q;

        // line status: sticky until its register is read
        if (lsr_evt_i)      st_d.pend.ls = 1'b1;
        else if (lsr_rd_i)  st_d.pend.ls = 1'b0;

        // received data follows the available level, dropped on a read
        st_d.pend.rda = rx_avail_i & ~rbr_rd_i;

        // timeout exists only in FIFO mode
        if (!fifo_mode_i)   st_d.pend.tmo = 1'b0;
        else if (tmo_evt_i) st_d.pend.tmo = 1'b1;
        else if (rbr_rd_i)  st_d.pend.tmo = 1'b0;

        // transmit empty: edge of the condition or of its enable
        thre_set = (thr_empty_i & ~st_q.empty_prev) |
                   (thr_empty_i & tx_en_i & ~st_q.tx_en_prev);
        thre_clr = thr_wr_i | (iir_rd_i && shown_id_i == ID_THRE);
        if (thre_set)       st_d.pend.thre = 1'b1;
        else if (thre_clr)  st_d.pend.thre = 1'b0;

        // modem status: sticky until its register is read
        if (msr_evt_i)      st_d.pend.ms = 1'b1;
        else if (msr_rd_i)  st_d.pend.ms = 1'b0;

        st_d.empty_prev = thr_empty_i;
        st_d.tx_en_prev = tx_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend       <= '0;
            st_q.empty_prev <= 1'b1;
            st_q.tx_en_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    assert_ls_read_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && !lsr_evt_i) |=> !pend_o.ls);
    assert_ls_event_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_evt_i |=> pend_o.ls);
    assert_rda_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd_i |=> !pend_o.rda);
    assert_tmo_fifo_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode_i |=> !pend_o.tmo);
    assert_thre_write_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !thr_empty_i) |=> !pend_o.thre);
    assert_ms_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && !msr_evt_i) |=> !pend_o.ms);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  irq_pend_t        pend_i,
    input  logic [IEN_W-1:0] ien_i,
    input  logic             fifo_mode_i,
    output logic             irq_o,
    output logic [IIR_W-1:0] iir_o
);

    irq_pend_t       gated;
    logic [ID_W-1:0] id_d;

    always_comb begin
        gated.ls   = pend_i.ls   & ien_i[EN_LS];
        gated.tmo  = pend_i.tmo  & ien_i[EN_RX] & fifo_mode_i;
        gated.rda  = pend_i.rda  & ien_i[EN_RX];
        gated.thre = pend_i.thre & ien_i[EN_TX];
        gated.ms   = pend_i.ms   & ien_i[EN_MS];

        if (gated.ls)        id_d = ID_LS;
        else if (gated.tmo)  id_d = ID_TMO;
        else if (gated.rda)  id_d = ID_RDA;
        else if (gated.thre) id_d = ID_THRE;
        else if (gated.ms)   id_d = ID_MS;
        else                 id_d = ID_NONE;

        irq_o = |gated;
        iir_o = {{2{fifo_mode_i}}, 2'b00, id_d};
    end

    assert_ls_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i.ls && ien_i[EN_LS]) |-> (iir_o[3:0] == ID_LS));
    assert_none_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (iir_o[3:0] == ID_NONE));
    assert_bit3_fifo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode_i |-> !iir_o[3]);
    assert_upper_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_o[7:4] == {{2{fifo_mode_i}}, 2'b00}));
    assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_i == '0) |-> !irq_o);

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode_i,
    input  logic [IEN_W-1:0] ien_i,
    input  logic             lsr_evt_i,
    input  logic             rx_avail_i,
    input  logic             tmo_evt_i,
    input  logic             thr_empty_i,
    input  logic             msr_evt_i,
    input  logic             lsr_rd_i,
    input  logic             rbr_rd_i,
    input  logic             thr_wr_i,
    input  logic             iir_rd_i,
    input  logic             msr_rd_i,
    output logic             irq_o,
    output logic [IIR_W-1:0] iir_o
);

    irq_pend_t pend;

    uart_irq_src_track track_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_mode_i (fifo_mode_i),
        .tx_en_i     (ien_i[EN_TX]),
        .lsr_evt_i   (lsr_evt_i),
        .rx_avail_i  (rx_avail_i),
        .tmo_evt_i   (tmo_evt_i),
        .thr_empty_i (thr_empty_i),
        .msr_evt_i   (msr_evt_i),
        .lsr_rd_i    (lsr_rd_i),
        .rbr_rd_i    (rbr_rd_i),
        .thr_wr_i    (thr_wr_i),
        .iir_rd_i    (iir_rd_i),
        .msr_rd_i    (msr_rd_i),
        .shown_id_i  (iir_o[ID_W-1:0]),
        .pend_o      (pend)
    );

    uart_irq_prio prio_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .ien_i       (ien_i),
        .fifo_mode_i (fifo_mode_i),
        .irq_o       (irq_o),
        .iir_o       (iir_o)
    );

    assert_irq_vs_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o != iir_o[0]);

endmodule

// File: tb/uart_irq_arbiter_tb_top.sv
module uart_irq_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode_i = 1'b0;
    logic [3:0] ien_i = 4'h0;
    logic       lsr_evt_i = 0, rx_avail_i = 0, tmo_evt_i = 0, thr_empty_i = 1, msr_evt_i = 0;
    logic       lsr_rd_i = 0, rbr_rd_i = 0, thr_wr_i = 0, iir_rd_i = 0, msr_rd_i = 0;
    logic       irq_o;
    logic [7:0] iir_o;

    always #2.5 clk = ~clk;

    uart_irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .ien_i(ien_i),
        .lsr_evt_i(lsr_evt_i), .rx_avail_i(rx_avail_i), .tmo_evt_i(tmo_evt_i),
        .thr_empty_i(thr_empty_i), .msr_evt_i(msr_evt_i), .lsr_rd_i(lsr_rd_i),
        .rbr_rd_i(rbr_rd_i), .thr_wr_i(thr_wr_i), .iir_rd_i(iir_rd_i),
        .msr_rd_i(msr_rd_i), .irq_o(irq_o), .iir_o(iir_o)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    string tag    = "R1";

    // reference state
    bit m_ls, m_tmo, m_rda, m_thre, m_ms, m_empty_prev, m_en_prev;

    function automatic logic [3:0] exp_id();
        bit en_rx = ien_i[0];
        if (m_ls && ien_i[2])                     return 4'b0110;
        if (m_tmo && en_rx && fifo_mode_i)        return 4'b1100;
        if (m_rda && en_rx)                       return 4'b0100;
        if (m_thre && ien_i[1])                   return 4'b0010;
        if (m_ms && ien_i[3])                     return 4'b0000;
        return 4'b0001;
    endfunction

    function automatic logic [7:0] exp_iir();
        return {{2{fifo_mode_i}}, 2'b00, exp_id()};
    endfunction

    task automatic check();
        logic [7:0] e = exp_iir();
        logic       ei = (e[0] == 1'b0);
        n_checks++;
        if (iir_o !== e || irq_o !== ei) begin
            n_fail++;
            $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", tag, iir_o, irq_o, e, ei);
        end
    endtask

    task automatic tick();
        bit n_ls, n_tmo, n_rda, n_thre, n_ms, set_t, clr_t;
        n_ls  = lsr_evt_i ? 1'b1 : (lsr_rd_i ? 1'b0 : m_ls);
        n_rda = rx_avail_i && !rbr_rd_i;
        n_tmo = !fifo_mode_i ? 1'b0 : (tmo_evt_i ? 1'b1 : (rbr_rd_i ? 1'b0 : m_tmo));
        set_t = (thr_empty_i && !m_empty_prev) || (thr_empty_i && ien_i[1] && !m_en_prev);
        clr_t = thr_wr_i || (iir_rd_i && exp_id() == 4'b0010);
        n_thre = set_t ? 1'b1 : (clr_t ? 1'b0 : m_thre);
        n_ms  = msr_evt_i ? 1'b1 : (msr_rd_i ? 1'b0 : m_ms);
        m_empty_prev = thr_empty_i;
        m_en_prev = ien_i[1];
        @(posedge clk);
        #1;
        m_ls = n_ls; m_rda = n_rda; m_tmo = n_tmo; m_thre = n_thre; m_ms = n_ms;
        {lsr_evt_i, tmo_evt_i, msr_evt_i, lsr_rd_i, rbr_rd_i, thr_wr_i, iir_rd_i, msr_rd_i} = '0;
        check();
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        {m_ls, m_tmo, m_rda, m_thre, m_ms} = '0;
        m_empty_prev = 1; m_en_prev = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        tag = "R1"; check();
        tick();

        tag = "R10"; fifo_mode_i = 1; tick();

        // line status set and cleared
        tag = "R2"; ien_i = 4'hF; lsr_evt_i = 1; tick();
        tick();
        lsr_evt_i = 1; lsr_rd_i = 1; tick();   // event wins over read
        lsr_rd_i = 1; tick();

        // enable gating of modem source
        tag = "R8"; ien_i = 4'h0; msr_evt_i = 1; tick();
        tick();
        ien_i = 4'h8; tick();
        tag = "R7"; msr_rd_i = 1; tick();

        // transmit empty via enable rise, cleared by IIR read
        tag = "R5"; ien_i = 4'h0; tick();
        ien_i = 4'h2; tick();
        tag = "R6"; iir_rd_i = 1; tick();
        tag = "R5"; thr_empty_i = 0; tick();
        thr_empty_i = 1; tick();
        tag = "R6"; thr_empty_i = 0; thr_wr_i = 1; tick();
        thr_empty_i = 1; tick();
        // IIR read while a higher source is showing keeps transmit empty
        ien_i = 4'h6; lsr_evt_i = 1; tick();
        iir_rd_i = 1; tick();
        lsr_rd_i = 1; tick();
        iir_rd_i = 1; tick();

        // second-level sources
        tag = "R3"; ien_i = 4'hF; rx_avail_i = 1; tick();
        rbr_rd_i = 1; tick();
        tick();
        tag = "R4"; tmo_evt_i = 1; tick();
        tick();
        fifo_mode_i = 0; tick();
        tag = "R10"; tick();
        fifo_mode_i = 1; tmo_evt_i = 1; tick();
        tag = "R4"; rbr_rd_i = 1; tick();
        tag = "R3"; rx_avail_i = 0; tick();

        // all together: priority order
        tag = "R11"; lsr_evt_i = 1; msr_evt_i = 1; tmo_evt_i = 1; rx_avail_i = 1; tick();
        lsr_rd_i = 1; tick();
        rbr_rd_i = 1; rx_avail_i = 0; tick();
        thr_wr_i = 1; thr_empty_i = 0; tick();
        msr_rd_i = 1; tick();

        // random mix
        tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            fifo_mode_i = ($urandom_range(0, 15) != 0);
            if ($urandom_range(0, 7) == 0) ien_i = 4'($urandom);
            lsr_evt_i   = ($urandom_range(0, 9) == 0);
            tmo_evt_i   = ($urandom_range(0, 9) == 0);
            msr_evt_i   = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) rx_avail_i = ~rx_avail_i;
            if ($urandom_range(0, 4) == 0) thr_empty_i = ~thr_empty_i;
            lsr_rd_i = ($urandom_range(0, 5) == 0);
            rbr_rd_i = ($urandom_range(0, 5) == 0);
            thr_wr_i = ($urandom_range(0, 7) == 0);
            iir_rd_i = ($urandom_range(0, 3) == 0);
            msr_rd_i = ($urandom_range(0, 5) == 0);
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule